// File: doc/BRIEF.md
# Single-Cycle Core Main Control Decoder

This block turns the opcode and function fields of a fetched instruction into every control signal that a single-cycle integer datapath needs in the same cycle. These are the register-file write enable, the destination-register choice, the second ALU operand choice and the write-back source. It also produces the memory read and write strobes, the branch, direct-jump and register-jump selects, and a three-bit operation code for the ALU control stage. It is purely combinational. A change on either input field settles on the outputs within the same cycle, with no register on the path.

Each of the three-way selects has one value more than the classic two-way form. The destination select can force register 31, the write-back select can pick the incremented program counter, and the operand select can pick a zero-extended immediate. With these values the core can run link-type jumps and unsigned or logical immediates. Any opcode outside the supported set produces an inert vector, so that no architectural state changes.

Top module: `main_ctl_decoder`

## Requirements
- R1: `dst_sel` is 0 for rt, 1 for rd and 2 for register 31. It is 1 for R-type opcodes, including jr and jalr, 2 for jal, and 0 for every other opcode.
- R2: `opb_sel` is 0 for the rt register, 1 for the sign-extended immediate and 2 for the zero-extended immediate. It is 1 for lw, sw and addi, 2 for andi, ori and sltiu, and 0 otherwise.
- R3: `wb_sel` is 0 for the ALU result, 1 for memory data and 2 for PC+4. It is 1 for lw, 2 for jal and jalr, and 0 otherwise.
- R4: `mem_rd` is high only for lw (opcode 0x23), and `mem_wr` is high only for sw (opcode 0x2B).
- R5: `reg_we` is high for R-type (except jr), lw, addi, andi, ori, sltiu, jal and jalr. It is low for sw, beq, j and jr.
- R6: `is_branch` is high only for beq (0x04). `is_jump` is high only for j (0x02) and jal (0x03). `is_jump_reg` is high only for opcode 0x00 with funct 0x08 (jr) or 0x09 (jalr). At most one of the three is high.
- R7: `alu_op` is 0 for add (lw, sw, addi, j, jal), 1 for subtract (beq), 2 for "use funct" (all R-type), 3 for and (andi), 4 for or (ori) and 5 for set-less-than-unsigned (sltiu).
- R8: `funct` has no effect on any output unless the opcode is 0x00.
- R9: Any opcode other than 0x00, 0x02, 0x03, 0x04, 0x08, 0x0B, 0x0C, 0x0D, 0x23 and 0x2B drives every output to zero.
- R10: The supported opcodes are R-type 0x00, j 0x02, jal 0x03, beq 0x04, addi 0x08, sltiu 0x0B, andi 0x0C, ori 0x0D, lw 0x23 and sw 0x2B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Instruction opcode field |
| funct | input | 6 | Instruction function field |
| reg_we | output | 1 | Register file write enable |
| dst_sel | output | 2 | Destination register select (0 rt, 1 rd, 2 r31) |
| opb_sel | output | 2 | Second ALU operand select (0 rt, 1 sign-ext imm, 2 zero-ext imm) |
| wb_sel | output | 2 | Write-back source (0 ALU, 1 memory, 2 PC+4) |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| is_branch | output | 1 | Conditional branch select, combined with ALU zero downstream |
| is_jump | output | 1 | Direct jump target select |
| is_jump_reg | output | 1 | Register jump target select |
| alu_op | output | 3 | Operation class for the ALU control stage |

## Verification
Every output is due zero cycles after its stimulus, because no register lies between the input fields and the control vector. The bench changes the opcode and funct just after a rising edge and compares all fields at the following falling edge. That gives the fields half a period to settle, and no edge ordering can affect the result. A behavioural reference model computes the expected vector for each input pair. The bench sweeps every opcode against several funct values and compares each field under its own requirement. It also re-applies each non-zero opcode with a different funct to confirm that the vector stays the same.

// File: rtl/main_ctl_pkg.sv
// Package: shared encodings for the main control decoder.
// Assumes 6-bit opcode and funct fields; select encodings are fixed
// because downstream multiplexers decode them.
package main_ctl_pkg;

    localparam int OP_W    = 6;
    localparam int FN_W    = 6;
    localparam int SEL_W   = 2;
    localparam int ALUOP_W = 3;

    // opcode values understood by the decoder
    localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OP_W-1:0] OPC_J     = 6'h02;
    localparam logic [OP_W-1:0] OPC_JAL   = 6'h03;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OP_W-1:0] OPC_ADDI  = 6'h08;
    localparam logic [OP_W-1:0] OPC_SLTIU = 6'h0B;
    localparam logic [OP_W-1:0] OPC_ANDI  = 6'h0C;
    localparam logic [OP_W-1:0] OPC_ORI   = 6'h0D;
    localparam logic [OP_W-1:0] OPC_LW    = 6'h23;
    localparam logic [OP_W-1:0] OPC_SW    = 6'h2B;

    // funct values that turn an R-type word into a register jump
    localparam logic [FN_W-1:0] FN_JR   = 6'h08;
    localparam logic [FN_W-1:0] FN_JALR = 6'h09;

    typedef enum logic [3:0] {
        CL_NONE, CL_RTYPE, CL_J, CL_JAL, CL_BEQ, CL_ADDI,
        CL_SLTIU, CL_ANDI, CL_ORI, CL_LW, CL_SW
    } op_class_e;

    typedef enum logic [1:0] { FN_PLAIN, FN_IS_JR, FN_IS_JALR } fn_class_e;

    typedef enum logic [SEL_W-1:0] { DST_RT = 2'd0, DST_RD = 2'd1, DST_R31 = 2'd2 } dst_sel_e;
    typedef enum logic [SEL_W-1:0] { OPB_REG = 2'd0, OPB_SEXT = 2'd1, OPB_ZEXT = 2'd2 } opb_sel_e;
    typedef enum logic [SEL_W-1:0] { WB_ALU = 2'd0, WB_MEM = 2'd1, WB_LINK = 2'd2 } wb_sel_e;

    typedef enum logic [ALUOP_W-1:0] {
        AOP_ADD = 3'd0, AOP_SUB = 3'd1, AOP_FUNCT = 3'd2,
        AOP_AND = 3'd3, AOP_OR  = 3'd4, AOP_SLTU  = 3'd5
    } alu_op_e;

    typedef struct packed {
        logic     reg_we;
        dst_sel_e dst;
        opb_sel_e opb;
        wb_sel_e  wb;
        logic     mem_rd;
        logic     mem_wr;
        logic     br;
        logic     jmp;
        logic     jmp_reg;
        alu_op_e  aop;
    } ctl_vec_t;

endpackage

// File: rtl/main_ctl_op_class.sv
// Module: classifies the opcode field into one instruction class.
// Assumes opcode values from main_ctl_pkg; anything else maps to CL_NONE.
module main_ctl_op_class
    import main_ctl_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output op_class_e       op_cls
);

    // map each supported opcode to its class
    always_comb begin
        unique case (opcode)
            OPC_RTYPE: op_cls = CL_RTYPE;
            OPC_J:     op_cls = CL_J;
            OPC_JAL:   op_cls = CL_JAL;
            OPC_BEQ:   op_cls = CL_BEQ;
            OPC_ADDI:  op_cls = CL_ADDI;
            OPC_SLTIU: op_cls = CL_SLTIU;
            OPC_ANDI:  op_cls = CL_ANDI;
            OPC_ORI:   op_cls = CL_ORI;
            OPC_LW:    op_cls = CL_LW;
            OPC_SW:    op_cls = CL_SW;
            default:   op_cls = CL_NONE;
        endcase
    end

endmodule

// File: rtl/main_ctl_fn_class.sv
// Module: spots the register-jump function codes within R-type words.
// Assumes the caller only trusts the result when the opcode is R-type.
module main_ctl_fn_class
    import main_ctl_pkg::*;
(
    input  logic [FN_W-1:0] funct,
    output fn_class_e       fn_cls
);

    // distinguish jr, jalr and ordinary R-type operations
    always_comb begin
        if (funct == FN_JR)        fn_cls = FN_IS_JR;
        else if (funct == FN_JALR) fn_cls = FN_IS_JALR;
        else                       fn_cls = FN_PLAIN;
    end

endmodule

// File: rtl/main_ctl_vec_gen.sv
// Module: builds the full control vector from the instruction class.
// Assumes fn_cls is meaningful only when op_cls is CL_RTYPE; every field
// of an unknown class is zero so no state is written.
module main_ctl_vec_gen
    import main_ctl_pkg::*;
(
    input  op_class_e op_cls,
    input  fn_class_e fn_cls,
    output ctl_vec_t  vec
);

    // start from an inert vector and set the fields each class needs
    always_comb begin
        vec = '{reg_we: 1'b0, dst: DST_RT, opb: OPB_REG, wb: WB_ALU,
                mem_rd: 1'b0, mem_wr: 1'b0, br: 1'b0, jmp: 1'b0,
                jmp_reg: 1'b0, aop: AOP_ADD};
        unique case (op_cls)
            CL_RTYPE: begin
                vec.dst = DST_RD;
                vec.aop = AOP_FUNCT;
                vec.reg_we  = (fn_cls != FN_IS_JR);
                vec.jmp_reg = (fn_cls != FN_PLAIN);
                if (fn_cls == FN_IS_JALR) vec.wb = WB_LINK;
            end
            CL_J: vec.jmp = 1'b1;
            CL_JAL: begin
                vec.jmp    = 1'b1;
                vec.reg_we = 1'b1;
                vec.dst    = DST_R31;
                vec.wb     = WB_LINK;
            end
            CL_BEQ: begin
                vec.br  = 1'b1;
                vec.aop = AOP_SUB;
            end
            CL_ADDI: begin
                vec.reg_we = 1'b1;
                vec.opb    = OPB_SEXT;
            end
            CL_SLTIU: begin
                vec.reg_we = 1'b1;
                vec.opb    = OPB_ZEXT;
                vec.aop    = AOP_SLTU;
            end
            CL_ANDI: begin
                vec.reg_we = 1'b1;
                vec.opb    = OPB_ZEXT;
                vec.aop    = AOP_AND;
            end
            CL_ORI: begin
                vec.reg_we = 1'b1;
                vec.opb    = OPB_ZEXT;
                vec.aop    = AOP_OR;
            end
            CL_LW: begin
                vec.reg_we = 1'b1;
                vec.opb    = OPB_SEXT;
                vec.wb     = WB_MEM;
                vec.mem_rd = 1'b1;
            end
            CL_SW: begin
                vec.opb    = OPB_SEXT;
                vec.mem_wr = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/main_ctl_decoder.sv
// Module: top of the main control decoder for a single-cycle core.
// Purely combinational: outputs follow opcode/funct in the same cycle.
// Assumes the datapath gates is_branch with the ALU zero flag.
module main_ctl_decoder
    import main_ctl_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output logic       reg_we,
    output logic [1:0] dst_sel,
    output logic [1:0] opb_sel,
    output logic [1:0] wb_sel,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       is_branch,
    output logic       is_jump,
    output logic       is_jump_reg,
    output logic [2:0] alu_op
);

    op_class_e op_cls;
    fn_class_e fn_cls;
    ctl_vec_t  vec;

    main_ctl_op_class u_op_class (.opcode(opcode), .op_cls(op_cls));
    main_ctl_fn_class u_fn_class (.funct(funct), .fn_cls(fn_cls));
    main_ctl_vec_gen  u_vec_gen  (.op_cls(op_cls), .fn_cls(fn_cls), .vec(vec));

    // unpack the control vector onto the ports
    always_comb begin
        reg_we      = vec.reg_we;
        dst_sel     = vec.dst;
        opb_sel     = vec.opb;
        wb_sel      = vec.wb;
        mem_rd      = vec.mem_rd;
        mem_wr      = vec.mem_wr;
        is_branch   = vec.br;
        is_jump     = vec.jmp;
        is_jump_reg = vec.jmp_reg;
        alu_op      = vec.aop;
    end

endmodule

// File: rtl/main_ctl_decoder_chk.sv
// Module: consistency checker for main_ctl_decoder, attached by bind.
// Combinational block, so checks are immediate assertions on settled values.
module main_ctl_decoder_chk (
    input logic [5:0] opcode,
    input logic [5:0] funct,
    input logic       reg_we,
    input logic [1:0] dst_sel,
    input logic [1:0] opb_sel,
    input logic [1:0] wb_sel,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       is_branch,
    input logic       is_jump,
    input logic       is_jump_reg,
    input logic [2:0] alu_op
);

    // cross-field rules between ports
    always_comb begin
        assert_rd_only_load_R4: assert (!mem_rd || opcode == 6'h23)
            else $error("mem_rd on non-load opcode %h", opcode);
        assert_wr_only_store_R4: assert (!mem_wr || opcode == 6'h2B)
            else $error("mem_wr on non-store opcode %h", opcode);
        assert_one_pc_source_R6: assert ($onehot0({is_branch, is_jump, is_jump_reg}))
            else $error("several next-PC selects high");
        assert_link_writes_R3: assert (wb_sel != 2'd2 || (reg_we && (is_jump || is_jump_reg)))
            else $error("link write-back without a writing jump");
        assert_r31_only_jal_R1: assert (dst_sel != 2'd2 || opcode == 6'h03)
            else $error("r31 destination on opcode %h", opcode);
        assert_zext_imm_ops_R2: assert (opb_sel != 2'd2 || opcode inside {6'h0B, 6'h0C, 6'h0D})
            else $error("zero-extended operand on opcode %h", opcode);
        assert_no_write_store_R5: assert (!(mem_wr && reg_we))
            else $error("store writes a register");
        assert_jreg_rtype_R6: assert (!is_jump_reg || (opcode == 6'h00 && funct inside {6'h08, 6'h09}))
            else $error("register jump outside jr/jalr");
        assert_sel_range_R7: assert (alu_op <= 3'd5 && dst_sel != 2'd3 && opb_sel != 2'd3 && wb_sel != 2'd3)
            else $error("reserved select encoding");
    end

endmodule

bind main_ctl_decoder main_ctl_decoder_chk u_chk (
    .opcode(opcode), .funct(funct), .reg_we(reg_we), .dst_sel(dst_sel),
    .opb_sel(opb_sel), .wb_sel(wb_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .is_branch(is_branch), .is_jump(is_jump), .is_jump_reg(is_jump_reg),
    .alu_op(alu_op)
);

// File: tb/tb_main_ctl_decoder.sv
// Bench: behavioural reference model compared against the decoder each cycle.
module tb_main_ctl_decoder;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [5:0] opcode = '0;
    logic [5:0] funct = '0;
    logic       reg_we, mem_rd, mem_wr, is_branch, is_jump, is_jump_reg;
    logic [1:0] dst_sel, opb_sel, wb_sel;
    logic [2:0] alu_op;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    main_ctl_decoder dut (
        .opcode(opcode), .funct(funct), .reg_we(reg_we), .dst_sel(dst_sel),
        .opb_sel(opb_sel), .wb_sel(wb_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .is_branch(is_branch), .is_jump(is_jump), .is_jump_reg(is_jump_reg),
        .alu_op(alu_op)
    );

    // expected fields, filled by the reference model
    logic       e_we, e_rd, e_wr, e_br, e_j, e_jr, e_known;
    logic [1:0] e_dst, e_opb, e_wb;
    logic [2:0] e_aop;

    task automatic model(input logic [5:0] op, input logic [5:0] fn);
        e_we = 0; e_rd = 0; e_wr = 0; e_br = 0; e_j = 0; e_jr = 0;
        e_dst = 0; e_opb = 0; e_wb = 0; e_aop = 0; e_known = 1;
        if (op == 6'h00) begin
            e_dst = 1; e_aop = 2;
            e_we = (fn != 6'h08);
            e_jr = (fn == 6'h08 || fn == 6'h09);
            if (fn == 6'h09) e_wb = 2;
        end else if (op == 6'h02) e_j = 1;
        else if (op == 6'h03) begin e_j = 1; e_we = 1; e_dst = 2; e_wb = 2; end
        else if (op == 6'h04) begin e_br = 1; e_aop = 1; end
        else if (op == 6'h08) begin e_we = 1; e_opb = 1; end
        else if (op == 6'h0B) begin e_we = 1; e_opb = 2; e_aop = 5; end
        else if (op == 6'h0C) begin e_we = 1; e_opb = 2; e_aop = 3; end
        else if (op == 6'h0D) begin e_we = 1; e_opb = 2; e_aop = 4; end
        else if (op == 6'h23) begin e_we = 1; e_opb = 1; e_wb = 1; e_rd = 1; end
        else if (op == 6'h2B) begin e_opb = 1; e_wr = 1; end
        else e_known = 0;
    endtask

    task automatic chk(input string req, input int act, input int exp, input logic [5:0] op, input logic [5:0] fn);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s op=%h fn=%h actual=%0d expected=%0d", req, op, fn, act, exp);
        end
    endtask

    // drive one instruction after a rising edge, compare at the falling edge
    task automatic apply(input logic [5:0] op, input logic [5:0] fn);
        @(posedge clk);
        #1;
        opcode = op;
        funct = fn;
        @(negedge clk);
        model(op, fn);
        if (!e_known) begin
            // R9: unknown opcode gives an all-zero vector
            chk("R9", {reg_we, dst_sel, opb_sel, wb_sel, mem_rd, mem_wr,
                       is_branch, is_jump, is_jump_reg, alu_op}, 0, op, fn);
        end else begin
            chk("R1 dst_sel", dst_sel, e_dst, op, fn);
            chk("R2 opb_sel", opb_sel, e_opb, op, fn);
            chk("R3 wb_sel", wb_sel, e_wb, op, fn);
            chk("R4 mem_rd", mem_rd, e_rd, op, fn);
            chk("R4 mem_wr", mem_wr, e_wr, op, fn);
            chk("R5 reg_we", reg_we, e_we, op, fn);
            chk("R6 is_branch", is_branch, e_br, op, fn);
            chk("R6 is_jump", is_jump, e_j, op, fn);
            chk("R6 is_jump_reg", is_jump_reg, e_jr, op, fn);
            chk("R7 alu_op", alu_op, e_aop, op, fn);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [14:0] ref_vec;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset state with all-zero inputs: a plain R-type word (R1, R5, R7)
        @(negedge clk);
        chk("R5 reset reg_we", reg_we, 1, opcode, funct);
        chk("R1 reset dst_sel", dst_sel, 1, opcode, funct);
        chk("R7 reset alu_op", alu_op, 2, opcode, funct);
        // R10: each supported opcode, and jr/jalr corner cases
        apply(6'h00, 6'h20); apply(6'h00, 6'h08); apply(6'h00, 6'h09);
        apply(6'h02, 6'h00); apply(6'h03, 6'h00); apply(6'h04, 6'h00);
        apply(6'h08, 6'h00); apply(6'h0B, 6'h00); apply(6'h0C, 6'h00);
        apply(6'h0D, 6'h00); apply(6'h23, 6'h00); apply(6'h2B, 6'h00);
        // full opcode sweep against several funct values (R9, R10)
        for (int op = 0; op < 64; op++) begin
            apply(6'(op), 6'h20);
            apply(6'(op), 6'h2A);
            apply(6'(op), 6'h3F);
        end
        // R8: funct must not change the vector of a non-zero opcode
        for (int op = 1; op < 64; op++) begin
            apply(6'(op), 6'h00);
            ref_vec = {reg_we, dst_sel, opb_sel, wb_sel, mem_rd, mem_wr,
                       is_branch, is_jump, is_jump_reg, alu_op};
            apply(6'(op), 6'h09);
            chk("R8 funct ignored", {reg_we, dst_sel, opb_sel, wb_sel, mem_rd, mem_wr,
                                     is_branch, is_jump, is_jump_reg, alu_op},
                ref_vec, 6'(op), 6'h09);
            apply(6'(op), 6'h08);
            chk("R8 funct ignored", {reg_we, dst_sel, opb_sel, wb_sel, mem_rd, mem_wr,
                                     is_branch, is_jump, is_jump_reg, alu_op},
                ref_vec, 6'(op), 6'h08);
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule